// File: doc/BRIEF.md
# Message-Driven Compute Site

This block is a single processing site in a fabric where work travels as 64-bit messages. Each message carries an opcode, a destination, a 32-bit operand value, and a follow-on opcode and destination. The site holds one operand register. A message either loads that register or combines its value with it. Arithmetic uses signed Q16.16 fixed point.

Load messages also capture the follow-on opcode and destination. The streaming arithmetic operations use those captured fields to build a fresh outgoing message that carries the result. A chain of sites can therefore be programmed once and then run on data messages alone, without any instruction memory. The non-streaming operations write the result back into the operand register, so a site can also serve as an accumulator.

Messages arrive on a valid/ready input port and leave on a valid/ready output port. The site accepts only messages whose destination matches its own address, which is given by the parameter `SITE_ADDR` (default 0x005). Division runs on a bit-serial divider. While a division is in progress, or while an outgoing message waits, the input port is held not-ready.

Top module: `msg_site`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and err_flag is 0. The operand register, the follow-on opcode and the follow-on destination are all zero.
- R2: Message layout: bits 3:0 hold the opcode, bits 15:4 the destination, bits 47:16 the value, bits 51:48 the follow-on opcode and bits 63:52 the follow-on destination. An accepted load message (opcode 0x1) writes its value to the operand register and latches its follow-on opcode and follow-on destination.
- R3: An overwrite message (opcode 0xD) replaces the operand with the message value and leaves the latched follow-on fields unchanged.
- R4: Opcode 0x4 stores operand+value and opcode 0x5 stores operand−value. Both use two's-complement wraparound.
- R5: Opcode 0x2 stores the 64-bit signed product shifted right arithmetically by 16 and truncated to 32 bits.
- R6: The streaming opcodes are 0x7 (add), 0x8 (subtract), 0x9 (multiply) and 0xA (divide). They leave the operand unchanged and emit one message. In that message, bits 3:0 hold the latched follow-on opcode, bits 15:4 the latched follow-on destination, bits 47:16 the result, and bits 63:48 are zero.
- R7: A pending output message holds out_valid and keeps all its bits stable until out_ready is seen. While it is pending, in_ready stays 0.
- R8: Opcode 0x6 stores operand/value, and 0xA streams it. The quotient is (operand·2^16)/value, rounded toward zero and saturated to 0x7FFFFFFF or 0x80000000. in_ready is 0 in the cycle after a division by a nonzero value is accepted, and stays 0 until the result is written or emitted.
- R9: Division by zero yields 0x7FFFFFFF when the operand is non-negative and 0x80000000 when it is negative.
- R10: An accepted message with an undefined opcode (0x0, 0x3, 0xB, 0xC, 0xE, 0xF) changes no operand or follow-on state and emits nothing. It sets err_flag, which stays 1 until reset.
- R11: An accepted message whose destination differs from SITE_ADDR is dropped without changing any state, and it sets err_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input message valid |
| in_ready | output | 1 | Site can accept a message |
| in_msg | input | 64 | Incoming message |
| out_valid | output | 1 | Outgoing message valid |
| out_ready | input | 1 | Downstream accepts outgoing message |
| out_msg | output | 64 | Outgoing message |
| err_flag | output | 1 | Sticky flag for undefined opcode or wrong destination |

## Verification
The following properties are checked on every cycle:
- A pending output stays stable and blocks the input.
- The error flag is sticky, and a bad opcode or destination raises it.
- An accepted streaming add, subtract or multiply produces an output on the next cycle.
- A nonzero division closes the input port.

The arithmetic itself can only be shown by the bench's scenarios. That covers wraparound, the truncation direction of multiply and divide, saturation and the divide-by-zero results. The scenarios also show that a load latches the follow-on fields, that overwrite leaves them alone, and that dropped messages leave the operand untouched. The bench reads the operand back by streaming an add of zero.

// File: rtl/site_pkg.sv
package site_pkg;
    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OP_LOAD = 4'h1;
    localparam logic [OPC_W-1:0] OP_SET  = 4'hD;
    localparam logic [OPC_W-1:0] OP_ACC  = 4'h4;
    localparam logic [OPC_W-1:0] OP_ACCS = 4'h7;
    localparam logic [OPC_W-1:0] OP_DIF  = 4'h5;
    localparam logic [OPC_W-1:0] OP_DIFS = 4'h8;
    localparam logic [OPC_W-1:0] OP_MUL  = 4'h2;
    localparam logic [OPC_W-1:0] OP_MULS = 4'h9;
    localparam logic [OPC_W-1:0] OP_DIV  = 4'h6;
    localparam logic [OPC_W-1:0] OP_DIVS = 4'hA;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DIV  = 2'd1,
        ST_OUT  = 2'd2
    } site_st_e;
endpackage

// File: rtl/site_alu.sv
module site_alu #(
    parameter int VAL_W  = 32,
    parameter int FRAC_W = 16
) (
    input  logic [VAL_W-1:0] a,
    input  logic [VAL_W-1:0] b,
    output logic [VAL_W-1:0] sum,
    output logic [VAL_W-1:0] dif,
    output logic [VAL_W-1:0] prod
);
    localparam int PW = 2 * VAL_W;

    logic signed [PW-1:0] a_x;
    logic signed [PW-1:0] b_x;

    always_comb begin
        a_x  = {{VAL_W{a[VAL_W-1]}}, a};
        b_x  = {{VAL_W{b[VAL_W-1]}}, b};
        sum  = a + b;
        dif  = a - b;
        prod = VAL_W'((a_x * b_x) >>> FRAC_W);
    end
endmodule

// File: rtl/site_div.sv
module site_div #(
    parameter int VAL_W  = 32,
    parameter int FRAC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VAL_W-1:0] dvd,
    input  logic [VAL_W-1:0] dvs,
    output logic             done,
    output logic [VAL_W-1:0] quo
);
    localparam int NUM_W = VAL_W + FRAC_W;
    localparam int CNT_W = $clog2(NUM_W + 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [NUM_W-1:0] num;
        logic [VAL_W-1:0] rem;
        logic [VAL_W-1:0] dvs;
        logic             neg;
    } div_s;

    div_s d_d, d_q;
    logic [VAL_W:0] trial;
    logic [NUM_W-1:0] pos_lim, neg_lim;

    always_comb begin
        d_d     = d_q;
        done    = 1'b0;
        trial   = {d_q.rem, d_q.num[NUM_W-1]};
        pos_lim = NUM_W'({1'b0, {(VAL_W-1){1'b1}}});
        neg_lim = NUM_W'({1'b1, {(VAL_W-1){1'b0}}});
        if (start) begin
            d_d.busy = 1'b1;
            d_d.cnt  = CNT_W'(NUM_W);
            d_d.num  = {(dvd[VAL_W-1] ? (~dvd + 1'b1) : dvd), {FRAC_W{1'b0}}};
            d_d.rem  = '0;
            d_d.dvs  = dvs[VAL_W-1] ? (~dvs + 1'b1) : dvs;
            d_d.neg  = dvd[VAL_W-1] ^ dvs[VAL_W-1];
        end else if (d_q.busy && d_q.cnt != '0) begin
            if (trial >= {1'b0, d_q.dvs}) begin
                d_d.rem = VAL_W'(trial - {1'b0, d_q.dvs});
                d_d.num = {d_q.num[NUM_W-2:0], 1'b1};
            end else begin
                d_d.rem = VAL_W'(trial);
                d_d.num = {d_q.num[NUM_W-2:0], 1'b0};
            end
            d_d.cnt = d_q.cnt - 1'b1;
        end else if (d_q.busy) begin
            done     = 1'b1;
            d_d.busy = 1'b0;
        end
        if (!d_q.neg)
            quo = (d_q.num > pos_lim) ? {1'b0, {(VAL_W-1){1'b1}}} : VAL_W'(d_q.num);
        else
            quo = (d_q.num > neg_lim) ? {1'b1, {(VAL_W-1){1'b0}}} : VAL_W'(~d_q.num + 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end
endmodule

// File: rtl/msg_site.sv
module msg_site
    import site_pkg::*;
#(
    parameter int          ADR_W     = 12,
    parameter int          VAL_W     = 32,
    parameter int          FRAC_W    = 16,
    parameter logic [11:0] SITE_ADDR = 12'h005
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid,
    output logic                            in_ready,
    input  logic [2*(OPC_W+ADR_W)+VAL_W-1:0] in_msg,
    output logic                            out_valid,
    input  logic                            out_ready,
    output logic [2*(OPC_W+ADR_W)+VAL_W-1:0] out_msg,
    output logic                            err_flag
);
    localparam int MSG_W   = 2 * (OPC_W + ADR_W) + VAL_W;
    localparam int DST_LSB = OPC_W;
    localparam int VAL_LSB = OPC_W + ADR_W;
    localparam int NOP_LSB = VAL_LSB + VAL_W;
    localparam int NDS_LSB = NOP_LSB + OPC_W;

    typedef struct packed {
        site_st_e         st;
        logic [VAL_W-1:0] opnd;
        logic [OPC_W-1:0] nop;
        logic [ADR_W-1:0] ndst;
        logic             err;
        logic             div_strm;
        logic [VAL_W-1:0] res;
    } site_s;

    site_s s_d, s_q;

    logic [OPC_W-1:0] m_op, m_nop;
    logic [ADR_W-1:0] m_dst, m_ndst;
    logic [VAL_W-1:0] m_val;
    logic [VAL_W-1:0] a_sum, a_dif, a_prod, dz_sat, d_quo;
    logic             fire, d_start, d_done;

    assign m_op   = in_msg[0 +: OPC_W];
    assign m_dst  = in_msg[DST_LSB +: ADR_W];
    assign m_val  = in_msg[VAL_LSB +: VAL_W];
    assign m_nop  = in_msg[NOP_LSB +: OPC_W];
    assign m_ndst = in_msg[NDS_LSB +: ADR_W];

    site_alu #(.VAL_W(VAL_W), .FRAC_W(FRAC_W)) u_alu (
        .a(s_q.opnd), .b(m_val), .sum(a_sum), .dif(a_dif), .prod(a_prod)
    );

    site_div #(.VAL_W(VAL_W), .FRAC_W(FRAC_W)) u_div (
        .clk(clk), .rst_n(rst_n), .start(d_start),
        .dvd(s_q.opnd), .dvs(m_val), .done(d_done), .quo(d_quo)
    );

    assign in_ready  = (s_q.st == ST_IDLE);
    assign out_valid = (s_q.st == ST_OUT);
    assign out_msg   = {{(OPC_W + ADR_W){1'b0}}, s_q.res, s_q.ndst, s_q.nop};
    assign err_flag  = s_q.err;

    always_comb begin
        s_d     = s_q;
        d_start = 1'b0;
        fire    = in_valid && (s_q.st == ST_IDLE);
        dz_sat  = s_q.opnd[VAL_W-1] ? {1'b1, {(VAL_W-1){1'b0}}}
                                    : {1'b0, {(VAL_W-1){1'b1}}};
        case (s_q.st)
            ST_IDLE: begin
                if (fire) begin
                    if (m_dst != ADR_W'(SITE_ADDR)) begin
                        s_d.err = 1'b1;
                    end else begin
                        case (m_op)
                            OP_LOAD: begin
                                s_d.opnd = m_val;
                                s_d.nop  = m_nop;
                                s_d.ndst = m_ndst;
                            end
                            OP_SET:  s_d.opnd = m_val;
                            OP_ACC:  s_d.opnd = a_sum;
                            OP_DIF:  s_d.opnd = a_dif;
                            OP_MUL:  s_d.opnd = a_prod;
                            OP_ACCS: begin s_d.res = a_sum;  s_d.st = ST_OUT; end
                            OP_DIFS: begin s_d.res = a_dif;  s_d.st = ST_OUT; end
                            OP_MULS: begin s_d.res = a_prod; s_d.st = ST_OUT; end
                            OP_DIV, OP_DIVS: begin
                                s_d.div_strm = (m_op == OP_DIVS);
                                if (m_val == '0) begin
                                    if (m_op == OP_DIVS) begin
                                        s_d.res = dz_sat;
                                        s_d.st  = ST_OUT;
                                    end else begin
                                        s_d.opnd = dz_sat;
                                    end
                                end else begin
                                    d_start = 1'b1;
                                    s_d.st  = ST_DIV;
                                end
                            end
                            default: s_d.err = 1'b1;
                        endcase
                    end
                end
            end
            ST_DIV: begin
                if (d_done) begin
                    if (s_q.div_strm) begin
                        s_d.res = d_quo;
                        s_d.st  = ST_OUT;
                    end else begin
                        s_d.opnd = d_quo;
                        s_d.st   = ST_IDLE;
                    end
                end
            end
            ST_OUT: begin
                if (out_ready) s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, default: '0};
        else        s_q <= s_d;
    end
endmodule

// File: rtl/site_chk.sv
module site_chk #(
    parameter int          ADR_W     = 12,
    parameter int          MSG_W     = 64,
    parameter logic [11:0] SITE_ADDR = 12'h005
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [3:0]       in_op,
    input logic [ADR_W-1:0] in_dst,
    input logic             in_val_nz,
    input logic             out_valid,
    input logic             out_ready,
    input logic [MSG_W-1:0] out_msg,
    input logic             err_flag
);
    logic acc, addr_ok, op_bad, op_strm;

    always_comb begin
        acc     = in_valid && in_ready;
        addr_ok = (in_dst == ADR_W'(SITE_ADDR));
        op_bad  = (in_op == 4'h0) || (in_op == 4'h3) || (in_op == 4'hB) ||
                  (in_op == 4'hC) || (in_op == 4'hE) || (in_op == 4'hF);
        op_strm = (in_op == 4'h7) || (in_op == 4'h8) || (in_op == 4'h9);
    end

    AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_msg)); // R7
    AST_IN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag); // R10
    AST_BAD_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
        acc && addr_ok && op_bad |=> err_flag); // R10
    AST_BAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !addr_ok |=> err_flag); // R11
    AST_STREAM_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        acc && addr_ok && op_strm |=> out_valid); // R6
    AST_DIV_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        acc && addr_ok && (in_op == 4'h6) && in_val_nz |=> !in_ready); // R8
endmodule

bind msg_site site_chk #(.ADR_W(ADR_W), .MSG_W(MSG_W), .SITE_ADDR(SITE_ADDR)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_msg[3:0]), .in_dst(in_msg[4 +: ADR_W]),
    .in_val_nz(|in_msg[4+ADR_W +: VAL_W]),
    .out_valid(out_valid), .out_ready(out_ready), .out_msg(out_msg),
    .err_flag(err_flag)
);

// File: tb/sim_msg_site.sv
module sim_msg_site;
    localparam logic [11:0] ME = 12'h005;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_msg = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [63:0] out_msg;
    logic        err_flag;
    int          errors = 0;
    int          checks = 0;

    always #4 clk = ~clk;

    msg_site u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_msg(in_msg), .out_valid(out_valid), .out_ready(out_ready),
        .out_msg(out_msg), .err_flag(err_flag)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] m_mul(logic signed [31:0] a, logic signed [31:0] b);
        longint p;
        p = (longint'(a) * longint'(b)) >>> 16;
        return p[31:0];
    endfunction

    function automatic logic [31:0] m_div(logic signed [31:0] a, logic signed [31:0] b);
        longint q;
        if (b == 0) return (a < 0) ? 32'h8000_0000 : 32'h7FFF_FFFF;
        q = (longint'(a) <<< 16) / longint'(b);
        if (q > 64'sd2147483647) return 32'h7FFF_FFFF;
        if (q < -64'sd2147483648) return 32'h8000_0000;
        return q[31:0];
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send(logic [3:0] op, logic [11:0] dst, logic [31:0] v,
                        logic [3:0] nop, logic [11:0] ndst);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_msg   = {ndst, nop, v, dst, op};
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic take(output logic [63:0] m);
        while (!out_valid) @(negedge clk);
        m = out_msg;
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic peek(output logic [63:0] m);
        send(4'h7, ME, 32'h0, 4'h0, 12'h0);
        take(m);
    endtask

    task automatic wait_idle();
        while (!in_ready) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [63:0] m;
        chk("R1 in_ready", 64'(in_ready), 64'd1);
        chk("R1 out_valid", 64'(out_valid), 64'd0);
        chk("R1 err_flag", 64'(err_flag), 64'd0);
        peek(m);
        chk("R1 zero state", m, 64'd0);
    endtask

    task automatic t_load_stream();
        logic [63:0] m;
        send(4'h1, ME, 32'h0001_8000, 4'h4, 12'h0AB);
        peek(m);
        chk("R2 load latches", m, {16'h0, 32'h0001_8000, 12'h0AB, 4'h4});
        send(4'h9, ME, 32'h0002_0000, 4'h0, 12'h0);
        take(m);
        chk("R6 MULS out", m, {16'h0, m_mul(32'h0001_8000, 32'h0002_0000), 12'h0AB, 4'h4});
        send(4'h8, ME, 32'h0000_8000, 4'h0, 12'h0);
        take(m);
        chk("R6 SUBS out", m, {16'h0, 32'h0001_0000, 12'h0AB, 4'h4});
        peek(m);
        chk("R6 operand kept", m[47:16], 64'h0001_8000);
    endtask

    task automatic t_hold();
        logic [63:0] first;
        send(4'h7, ME, 32'h0000_0001, 4'h0, 12'h0);
        first = out_msg;
        repeat (5) @(negedge clk);
        chk("R7 valid held", 64'(out_valid), 64'd1);
        chk("R7 in blocked", 64'(in_ready), 64'd0);
        chk("R7 msg stable", out_msg, first);
        chk("R7 msg value", first[47:16], 64'h0001_8001);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk("R7 released", 64'(out_valid), 64'd0);
        chk("R7 ready back", 64'(in_ready), 64'd1);
    endtask

    task automatic t_stored();
        logic [63:0] m;
        send(4'hD, ME, 32'h0003_0000, 4'h1, 12'h111);
        peek(m);
        chk("R3 update value", m[47:16], 64'h0003_0000);
        chk("R3 follow-on kept", m[15:0], {48'h0, 12'h0AB, 4'h4});
        send(4'h4, ME, 32'h0001_0000, 4'h0, 12'h0);
        peek(m);
        chk("R4 add", m[47:16], 64'h0004_0000);
        send(4'h5, ME, 32'h0005_0000, 4'h0, 12'h0);
        peek(m);
        chk("R4 sub", m[47:16], 64'hFFFF_0000);
        send(4'h2, ME, 32'hFFFE_8000, 4'h0, 12'h0);
        peek(m);
        chk("R5 mul neg*neg", m[47:16], 64'(m_mul(32'hFFFF_0000, 32'hFFFE_8000)));
        send(4'hD, ME, 32'hFFFF_FFFD, 4'h0, 12'h0);
        send(4'h2, ME, 32'h0000_8000, 4'h0, 12'h0);
        peek(m);
        chk("R5 mul floor", m[47:16], 64'hFFFF_FFFE);
        send(4'hD, ME, 32'h7FFF_FFFF, 4'h0, 12'h0);
        send(4'h4, ME, 32'h0000_0001, 4'h0, 12'h0);
        peek(m);
        chk("R4 add wrap", m[47:16], 64'h8000_0000);
    endtask

    task automatic t_div();
        logic [63:0] m;
        send(4'hD, ME, 32'h0007_0000, 4'h0, 12'h0);
        send(4'h6, ME, 32'h0002_0000, 4'h0, 12'h0);
        chk("R8 busy blocks", 64'(in_ready), 64'd0);
        wait_idle();
        peek(m);
        chk("R8 div", m[47:16], 64'h0003_8000);
        send(4'hD, ME, 32'hFFF9_0000, 4'h0, 12'h0);
        send(4'hA, ME, 32'h0002_0000, 4'h0, 12'h0);
        take(m);
        chk("R8 divs neg", m, {16'h0, m_div(32'hFFF9_0000, 32'h0002_0000), 12'h0AB, 4'h4});
        send(4'hD, ME, 32'hFFFF_FFFF, 4'h0, 12'h0);
        send(4'h6, ME, 32'h0003_0000, 4'h0, 12'h0);
        peek(m);
        chk("R8 trunc to zero", m[47:16], 64'(m_div(32'hFFFF_FFFF, 32'h0003_0000)));
        send(4'hD, ME, 32'h7FFF_0000, 4'h0, 12'h0);
        send(4'h6, ME, 32'h0000_8000, 4'h0, 12'h0);
        peek(m);
        chk("R8 sat pos", m[47:16], 64'h7FFF_FFFF);
        send(4'hD, ME, 32'h7FFF_0000, 4'h0, 12'h0);
        send(4'h6, ME, 32'hFFFF_8000, 4'h0, 12'h0);
        peek(m);
        chk("R8 sat neg", m[47:16], 64'h8000_0000);
        send(4'hD, ME, 32'hFFFB_0000, 4'h0, 12'h0);
        send(4'h6, ME, 32'h0, 4'h0, 12'h0);
        peek(m);
        chk("R9 div0 neg", m[47:16], 64'h8000_0000);
        send(4'hD, ME, 32'h0, 4'h0, 12'h0);
        send(4'hA, ME, 32'h0, 4'h0, 12'h0);
        take(m);
        chk("R9 divs0 zero", m[47:16], 64'h7FFF_FFFF);
    endtask

    task automatic t_addr();
        logic [63:0] m;
        send(4'h1, 12'h006, 32'h1234_5678, 4'h9, 12'h0FF);
        chk("R11 err set", 64'(err_flag), 64'd1);
        chk("R11 no output", 64'(out_valid), 64'd0);
        peek(m);
        chk("R11 state kept", m, {16'h0, 32'h0001_8000, 12'h0AB, 4'h4});
    endtask

    task automatic t_undef();
        logic [63:0] m;
        send(4'h1, ME, 32'h0000_4000, 4'h2, 12'h022);
        chk("R10 err clear", 64'(err_flag), 64'd0);
        send(4'hB, ME, 32'h5555_0000, 4'h7, 12'h777);
        chk("R10 err set", 64'(err_flag), 64'd1);
        chk("R10 no output", 64'(out_valid), 64'd0);
        peek(m);
        chk("R10 state kept", m, {16'h0, 32'h0000_4000, 12'h022, 4'h2});
        chk("R10 err sticky", 64'(err_flag), 64'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        t_reset();
        t_load_stream();
        t_hold();
        t_addr();
        do_reset();
        t_reset();
        t_undef();
        do_reset();
        send(4'h1, ME, 32'h0001_8000, 4'h4, 12'h0AB);
        t_stored();
        t_div();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule